// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block performs trap entry for a core with three privilege levels: user, supervisor and machine. A trap request carries the cause code, an interrupt flag and the address of the trapping instruction. The block picks the privilege level that will handle the trap by consulting two exception delegation registers. It then records the trap in that level's cause and exception-PC registers, saves and clears that level's interrupt-enable state in the shared status word, and raises the current privilege. It also emits a one-cycle redirect pulse that carries the handler address, taken from the target level's vector register.

Target selection has two stages. Machine level is the default handler. The machine delegation bit indexed by the cause code hands the trap down to supervisor, but only when the trap does not come from machine mode. After that, the supervisor delegation bit hands a trap raised in user mode on to user level. A small CSR write port loads the delegation registers, the three vector registers, the status word and the current privilege. The status word and privilege are writable so that software can set the state from which traps are taken.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset the current privilege is machine (3), the status word, delegation, vector, cause and exception-PC registers are all zero, redirect_valid is 0 and trap_ready is 1.
- R2: Privilege encoding is user=0, supervisor=1, machine=3. The target is machine unless the current privilege is not machine and bit [code] of the machine delegation register is set, in which case it is supervisor. A trap never lowers the privilege.
- R3: When the current privilege is user and bit [code] of the supervisor delegation register is set, the target is user. This applies whatever the machine delegation bit holds.
- R4: On a trap taken to supervisor: status bit 8 takes bit 0 of the prior privilege, status bit 5 takes status bit 1, and status bit 1 is cleared.
- R5: On a trap taken to machine: status bits 12:11 take the prior privilege, status bit 7 takes status bit 3, and status bit 3 is cleared.
- R6: On a trap taken to user: status bit 4 takes status bit 0 and status bit 0 is cleared. In every case the status bits not named for the target level keep their values.
- R7: Only the target level's cause register is written. It gets the interrupt flag in bit XLEN-1 and the cause code in the low bits, with zeros between. Only the target level's exception-PC register is written, and it gets trap_pc. The other levels' cause and exception-PC registers are unchanged.
- R8: The current privilege becomes the target level in the edge that accepts the trap.
- R9: redirect_valid is high for exactly the one cycle after the accepting edge. redirect_pc is the target vector register with bits 1:0 cleared.
- R10: trap_ready is low while redirect_valid is high. A request made in that cycle is dropped: it changes no state and produces no second pulse.
- R11: CSR write selects are 0 machine delegation, 1 supervisor delegation, 2 machine vector, 3 supervisor vector, 4 user vector, 5 status, 6 privilege; select 7 is ignored. A privilege write of value 2 is ignored, and the privilege takes only data bits 1:0.
- R12: A CSR write in the same cycle as an accepted trap is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request, accepted when trap_ready is high |
| trap_ready | output | 1 | Block can accept a trap this cycle |
| trap_code | input | CODE_W | Cause code, also indexes the delegation registers |
| trap_is_irq | input | 1 | Trap is an interrupt |
| trap_pc | input | XLEN | Address of the trapping instruction |
| csr_wr_en | input | 1 | CSR write strobe |
| csr_wr_sel | input | 3 | CSR write register select |
| csr_wr_data | input | XLEN | CSR write data |
| cur_priv | output | 2 | Current privilege |
| status | output | XLEN | Shared status word |
| mcause | output | XLEN | Machine cause register |
| scause | output | XLEN | Supervisor cause register |
| ucause | output | XLEN | User cause register |
| mepc | output | XLEN | Machine exception PC |
| sepc | output | XLEN | Supervisor exception PC |
| uepc | output | XLEN | User exception PC |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | XLEN | Handler address |

## Verification
Every result of an accepted trap is due in the cycle right after the accepting edge: cause, exception PC, status, privilege and the redirect pulse all change together in that single edge. The bench drives a request at a falling edge and reads every output at the next falling edge. It then reads once more one cycle later, where the pulse must be gone and trap_ready back high. A CSR write shows on the outputs one edge after its strobe. A request held over the pending cycle is checked two edges later against state that reflects the first trap alone.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    WSEL_MDELEG = 3'd0,
    WSEL_SDELEG = 3'd1,
    WSEL_MVEC   = 3'd2,
    WSEL_SVEC   = 3'd3,
    WSEL_UVEC   = 3'd4,
    WSEL_STATUS = 3'd5,
    WSEL_PRIV   = 3'd6,
    WSEL_NONE   = 3'd7
  } wsel_e;

  // status word bit positions
  localparam int ST_UIE    = 0;
  localparam int ST_SIE    = 1;
  localparam int ST_MIE    = 3;
  localparam int ST_UPIE   = 4;
  localparam int ST_SPIE   = 5;
  localparam int ST_MPIE   = 7;
  localparam int ST_SPP    = 8;
  localparam int ST_MPP_LO = 11;

  localparam int NLVL = 3;

  // storage slot for a privilege level: user 0, supervisor 1, machine 2
  function automatic int unsigned lvl_slot(priv_e p);
    case (p)
      PRIV_U:  return 0;
      PRIV_S:  return 1;
      default: return 2;
    endcase
  endfunction

  function automatic wsel_e vec_wsel(int unsigned slot);
    case (slot)
      0:       return WSEL_UVEC;
      1:       return WSEL_SVEC;
      default: return WSEL_MVEC;
    endcase
  endfunction

  // two-stage delegation: machine -> supervisor, then supervisor -> user
  function automatic priv_e pick_target(priv_e cur, logic m_bit, logic s_bit);
    priv_e t;
    t = PRIV_M;
    if (cur != PRIV_M && m_bit) t = PRIV_S;
    if (cur == PRIV_U && s_bit) t = PRIV_U;
    return t;
  endfunction

endpackage

// File: rtl/trap_target_sel.sv
module trap_target_sel
  import trap_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int CODE_W = 6
) (
  input  priv_e             cur_priv,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   mdeleg,
  input  logic [XLEN-1:0]   sdeleg,
  output priv_e             tgt_priv,
  output logic              m_hit,
  output logic              s_hit
);

  always_comb begin
    m_hit    = mdeleg[code];
    s_hit    = sdeleg[code];
    tgt_priv = pick_target(cur_priv, m_hit, s_hit);
  end

endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
  import trap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] st_old,
  input  priv_e           prior,
  input  priv_e           tgt,
  output logic [XLEN-1:0] st_new
);

  always_comb begin
    st_new = st_old;
    case (tgt)
      PRIV_M: begin
        st_new[ST_MPP_LO +: 2] = prior;
        st_new[ST_MPIE]        = st_old[ST_MIE];
        st_new[ST_MIE]         = 1'b0;
      end
      PRIV_S: begin
        st_new[ST_SPP]  = prior[0];
        st_new[ST_SPIE] = st_old[ST_SIE];
        st_new[ST_SIE]  = 1'b0;
      end
      PRIV_U: begin
        st_new[ST_UPIE] = st_old[ST_UIE];
        st_new[ST_UIE]  = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
  import trap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  priv_e           tgt_priv,
  input  logic [XLEN-1:0] status_next,
  input  logic [XLEN-1:0] cause_val,
  input  logic [XLEN-1:0] trap_pc,
  input  logic            csr_wr_en,
  input  logic [2:0]      csr_wr_sel,
  input  logic [XLEN-1:0] csr_wr_data,
  output priv_e           priv_q,
  output logic [XLEN-1:0] status_q,
  output logic [XLEN-1:0] mdeleg_q,
  output logic [XLEN-1:0] sdeleg_q,
  output logic [XLEN-1:0] cause_q [NLVL],
  output logic [XLEN-1:0] epc_q   [NLVL],
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);

  logic [XLEN-1:0] tvec_q [NLVL];
  logic            csr_go;
  int unsigned     tgt_slot;
  logic [XLEN-1:0] vec_sel;

  assign csr_go   = csr_wr_en && !accept;
  assign tgt_slot = lvl_slot(tgt_priv);
  assign vec_sel  = tvec_q[tgt_slot];

  genvar g;
  generate
    for (g = 0; g < NLVL; g++) begin : g_lvl
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cause_q[g] <= '0;
          epc_q[g]   <= '0;
          tvec_q[g]  <= '0;
        end else begin
          if (accept && tgt_slot == g) begin
            cause_q[g] <= cause_val;
            epc_q[g]   <= trap_pc;
          end
          if (csr_go && csr_wr_sel == vec_wsel(g)) tvec_q[g] <= csr_wr_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q         <= PRIV_M;
      status_q       <= '0;
      mdeleg_q       <= '0;
      sdeleg_q       <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= accept;
      if (accept) begin
        priv_q      <= tgt_priv;
        status_q    <= status_next;
        redirect_pc <= {vec_sel[XLEN-1:2], 2'b00};
      end else if (csr_go) begin
        case (wsel_e'(csr_wr_sel))
          WSEL_MDELEG: mdeleg_q <= csr_wr_data;
          WSEL_SDELEG: sdeleg_q <= csr_wr_data;
          WSEL_STATUS: status_q <= csr_wr_data;
          WSEL_PRIV:
            if (csr_wr_data[1:0] != 2'd2) priv_q <= priv_e'(csr_wr_data[1:0]);
          default: ;
        endcase
      end
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid); // R9
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> redirect_pc[1:0] == 2'b00); // R9
  AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    priv_q != PRIV_RSVD); // R11
  AST_EPC_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> epc_q[lvl_slot(priv_q)] == $past(trap_pc)); // R7
  AST_MIE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && priv_q == PRIV_M) |-> !status_q[ST_MIE]); // R5

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  output logic              trap_ready,
  input  logic [CODE_W-1:0] trap_code,
  input  logic              trap_is_irq,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              csr_wr_en,
  input  logic [2:0]        csr_wr_sel,
  input  logic [XLEN-1:0]   csr_wr_data,
  output logic [1:0]        cur_priv,
  output logic [XLEN-1:0]   status,
  output logic [XLEN-1:0]   mcause,
  output logic [XLEN-1:0]   scause,
  output logic [XLEN-1:0]   ucause,
  output logic [XLEN-1:0]   mepc,
  output logic [XLEN-1:0]   sepc,
  output logic [XLEN-1:0]   uepc,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc
);

  localparam int PAD_W = XLEN - 1 - CODE_W;

  priv_e           priv_q;
  priv_e           tgt_priv;
  logic            m_hit, s_hit;
  logic            accept;
  logic [XLEN-1:0] status_q, status_next, cause_val;
  logic [XLEN-1:0] mdeleg_q, sdeleg_q;
  logic [XLEN-1:0] cause_q [NLVL];
  logic [XLEN-1:0] epc_q   [NLVL];

  assign trap_ready = !redirect_valid;
  assign accept     = trap_req && trap_ready;
  assign cause_val  = {trap_is_irq, {PAD_W{1'b0}}, trap_code};

  trap_target_sel #(.XLEN(XLEN), .CODE_W(CODE_W)) u_sel (
    .cur_priv (priv_q),
    .code     (trap_code),
    .mdeleg   (mdeleg_q),
    .sdeleg   (sdeleg_q),
    .tgt_priv (tgt_priv),
    .m_hit    (m_hit),
    .s_hit    (s_hit)
  );

  trap_status_upd #(.XLEN(XLEN)) u_st (
    .st_old (status_q),
    .prior  (priv_q),
    .tgt    (tgt_priv),
    .st_new (status_next)
  );

  trap_state_regs #(.XLEN(XLEN)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .accept         (accept),
    .tgt_priv       (tgt_priv),
    .status_next    (status_next),
    .cause_val      (cause_val),
    .trap_pc        (trap_pc),
    .csr_wr_en      (csr_wr_en),
    .csr_wr_sel     (csr_wr_sel),
    .csr_wr_data    (csr_wr_data),
    .priv_q         (priv_q),
    .status_q       (status_q),
    .mdeleg_q       (mdeleg_q),
    .sdeleg_q       (sdeleg_q),
    .cause_q        (cause_q),
    .epc_q          (epc_q),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
  );

  assign cur_priv = priv_q;
  assign status   = status_q;
  assign ucause   = cause_q[0];
  assign scause   = cause_q[1];
  assign mcause   = cause_q[2];
  assign uepc     = epc_q[0];
  assign sepc     = epc_q[1];
  assign mepc     = epc_q[2];

  AST_NO_LOWERING: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> tgt_priv >= priv_q); // R2
  AST_UDELEG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && priv_q == PRIV_U && s_hit) |-> tgt_priv == PRIV_U); // R3
  AST_MDELEG_S: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && priv_q == PRIV_S && m_hit) |-> tgt_priv == PRIV_S); // R2
  AST_PENDING_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && trap_req && !csr_wr_en) |=>
      ($stable(status_q) && $stable(priv_q) && !redirect_valid)); // R10

endmodule

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;

  localparam int XLEN   = 64;
  localparam int CODE_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              trap_req = 1'b0;
  logic              trap_ready;
  logic [CODE_W-1:0] trap_code = '0;
  logic              trap_is_irq = 1'b0;
  logic [XLEN-1:0]   trap_pc = '0;
  logic              csr_wr_en = 1'b0;
  logic [2:0]        csr_wr_sel = '0;
  logic [XLEN-1:0]   csr_wr_data = '0;
  logic [1:0]        cur_priv;
  logic [XLEN-1:0]   status, mcause, scause, ucause, mepc, sepc, uepc;
  logic              redirect_valid;
  logic [XLEN-1:0]   redirect_pc;

  trap_entry_ctrl #(.XLEN(XLEN), .CODE_W(CODE_W)) dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_ready(trap_ready),
    .trap_code(trap_code), .trap_is_irq(trap_is_irq), .trap_pc(trap_pc),
    .csr_wr_en(csr_wr_en), .csr_wr_sel(csr_wr_sel), .csr_wr_data(csr_wr_data),
    .cur_priv(cur_priv), .status(status), .mcause(mcause), .scause(scause),
    .ucause(ucause), .mepc(mepc), .sepc(sepc), .uepc(uepc),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model of architectural state
  logic [1:0]      m_priv;
  logic [XLEN-1:0] m_status, m_md, m_sd;
  logic [XLEN-1:0] m_vec [3];
  logic [XLEN-1:0] m_cause [3];
  logic [XLEN-1:0] m_epc [3];
  logic [XLEN-1:0] m_rpc;

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int slot(logic [1:0] p);
    return (p == 2'd3) ? 2 : int'(p);
  endfunction

  function automatic logic [1:0] exp_target(logic [1:0] p, int code,
                                            logic [XLEN-1:0] md, logic [XLEN-1:0] sd);
    if (p == 2'd0 && sd[code]) return 2'd0;
    if (p != 2'd3 && md[code]) return 2'd1;
    return 2'd3;
  endfunction

  function automatic logic [XLEN-1:0] exp_status(logic [XLEN-1:0] s, logic [1:0] p,
                                                 logic [1:0] t);
    logic [XLEN-1:0] r;
    r = s;
    if (t == 2'd3) begin
      r = (r & ~(64'h3 << 11)) | (XLEN'(p) << 11);
      r = (r & ~(64'h1 << 7)) | (XLEN'(s[3]) << 7);
      r = r & ~(64'h1 << 3);
    end else if (t == 2'd1) begin
      r = (r & ~(64'h1 << 8)) | (XLEN'(p[0]) << 8);
      r = (r & ~(64'h1 << 5)) | (XLEN'(s[1]) << 5);
      r = r & ~(64'h1 << 1);
    end else begin
      r = (r & ~(64'h1 << 4)) | (XLEN'(s[0]) << 4);
      r = r & ~64'h1;
    end
    return r;
  endfunction

  task automatic check_state(string tag);
    chk({tag, " R8 priv"}, XLEN'(cur_priv), XLEN'(m_priv));
    chk({tag, " R4 R5 R6 status"}, status, m_status);
    chk({tag, " R7 ucause"}, ucause, m_cause[0]);
    chk({tag, " R7 scause"}, scause, m_cause[1]);
    chk({tag, " R7 mcause"}, mcause, m_cause[2]);
    chk({tag, " R7 uepc"}, uepc, m_epc[0]);
    chk({tag, " R7 sepc"}, sepc, m_epc[1]);
    chk({tag, " R7 mepc"}, mepc, m_epc[2]);
  endtask

  task automatic model_write(int sel, logic [XLEN-1:0] d);
    case (sel)
      0: m_md = d;
      1: m_sd = d;
      2: m_vec[2] = d;
      3: m_vec[1] = d;
      4: m_vec[0] = d;
      5: m_status = d;
      6: if (d[1:0] != 2'd2) m_priv = d[1:0];
      default: ;
    endcase
  endtask

  task automatic csr_write(int sel, logic [XLEN-1:0] d);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_wr_sel = 3'(sel); csr_wr_data = d;
    @(negedge clk);
    csr_wr_en = 1'b0;
    model_write(sel, d);
  endtask

  task automatic model_trap(int code, logic irq, logic [XLEN-1:0] pc);
    logic [1:0] t;
    t = exp_target(m_priv, code, m_md, m_sd);
    m_status = exp_status(m_status, m_priv, t);
    m_cause[slot(t)] = {irq, 63'(code)};
    m_epc[slot(t)] = pc;
    m_rpc = m_vec[slot(t)] & ~64'h3;
    m_priv = t;
  endtask

  task automatic do_trap(int code, logic irq, logic [XLEN-1:0] pc);
    @(negedge clk);
    trap_req = 1'b1; trap_code = CODE_W'(code); trap_is_irq = irq; trap_pc = pc;
    @(negedge clk);
    trap_req = 1'b0;
    model_trap(code, irq, pc);
    chk("R9 pulse high", XLEN'(redirect_valid), 1);
    chk("R9 redirect pc", redirect_pc, m_rpc);
    chk("R10 ready low", XLEN'(trap_ready), 0);
    check_state("trap");
    @(negedge clk);
    chk("R9 pulse ends", XLEN'(redirect_valid), 0);
    chk("R10 ready back", XLEN'(trap_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    int seed;
    logic [XLEN-1:0] held;
    seed = 32'd1234;
    void'($urandom(seed));
    m_priv = 2'd3; m_status = '0; m_md = '0; m_sd = '0; m_rpc = '0;
    for (int i = 0; i < 3; i++) begin m_vec[i] = '0; m_cause[i] = '0; m_epc[i] = '0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", XLEN'(trap_ready), 1);
    chk("R1 pulse", XLEN'(redirect_valid), 0);
    check_state("R1 reset");

    // directed: machine default from machine mode even with delegation set (R2)
    csr_write(0, '1); csr_write(1, '1);
    csr_write(2, 64'h8000_0103); csr_write(3, 64'h4000_0206); csr_write(4, 64'h2000_0301);
    csr_write(5, 64'h2B);
    do_trap(2, 1'b0, 64'h1000);
    // R3 user-mode trap with both delegations set goes to user
    csr_write(6, 64'h0); csr_write(5, 64'h3B);
    do_trap(8, 1'b0, 64'h1004);
    // R2 supervisor via machine delegation, R4
    csr_write(1, '0); csr_write(6, 64'h1);
    do_trap(13, 1'b1, 64'h2008);
    // R3 user with machine delegation clear
    csr_write(0, '0); csr_write(1, 64'h1 << 15); csr_write(6, 64'h0);
    do_trap(15, 1'b0, 64'h300C);
    // R11 privilege write of 2 ignored, select 7 ignored
    csr_write(6, 64'h2);
    chk("R11 priv 2 ignored", XLEN'(cur_priv), XLEN'(m_priv));
    csr_write(7, '1);
    check_state("R11 sel7");

    // R10 request held through the pending cycle is dropped
    @(negedge clk);
    trap_req = 1'b1; trap_code = 6'd1; trap_is_irq = 1'b0; trap_pc = 64'hAAA0;
    @(negedge clk);
    model_trap(1, 1'b0, 64'hAAA0);
    trap_pc = 64'hBBB0; trap_code = 6'd9;
    @(negedge clk);
    trap_req = 1'b0;
    chk("R10 no second pulse", XLEN'(redirect_valid), 0);
    check_state("R10 dropped");

    // R12 CSR write in the accepting cycle is discarded
    @(negedge clk);
    held = 64'hFFFF_0000_FFFF_FFFF;
    trap_req = 1'b1; trap_code = 6'd11; trap_pc = 64'hC0;
    csr_wr_en = 1'b1; csr_wr_sel = 3'd5; csr_wr_data = held;
    @(negedge clk);
    trap_req = 1'b0; csr_wr_en = 1'b0;
    model_trap(11, 1'b0, 64'hC0);
    chk("R12 write dropped", status, m_status);
    @(negedge clk);

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int pr;
      pr = $urandom % 3;
      if (it % 8 == 0) begin
        csr_write(0, {$urandom, $urandom});
        csr_write(1, {$urandom, $urandom});
        csr_write(2 + ($urandom % 3), {$urandom, $urandom});
      end
      csr_write(5, {$urandom, $urandom});
      csr_write(6, (pr == 2) ? 64'h3 : XLEN'(pr));
      do_trap($urandom % 64, 1'($urandom), {$urandom, $urandom});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule